// File: doc/BRIEF.md
# External-Clock SAR Conversion Sequencer

This block sequences a successive-approximation conversion whose every step is paced by the host's serial clock. The SCLK and chip-select pins are sampled in the system clock domain. After a command decoder upstream flags a start, the sequencer counts the counted falling SCLK edges of the frame. It raises a one-period strobe, walks a 14-bit trial code one bit per falling edge using the comparator decision, and shifts each decided bit onto the serial output in the same edge. The remaining frame positions are filled with zeros, and a done pulse marks the end of the frame.

Two acquisition lengths are supported. Long acquisition pushes the strobe, the data bits and the frame end eight SCLK periods later. The result is straight binary for unipolar conversions and two's complement for bipolar ones. Edges seen while chip select is high do not count, so a host can split the frame into 8-bit transfers. The start edge is numbered 7. It is the falling SCLK edge that follows the seventh command bit.

Top module: `xclk_sar_seq`

## Requirements
- R1: After reset `dout`, `sstrb`, `conv_done` and `sar_code` are all zero.
- R2: In short acquisition (`start_long`=0) `sstrb` goes high at the start edge (count 7) and low at count 8, so it is high for exactly one counted SCLK period.
- R3: In long acquisition (`start_long`=1) `sstrb` stays low until count 15, is high from count 15 to count 16, and the first data bit appears at count 16.
- R4: The 14 result bits appear on `dout` MSB first at the 14 counted falling edges after the strobe edge. `dout` is 0 at every other counted edge of the frame.
- R5: At the start edge `sar_code` becomes 14'h2000. At each data edge bit k takes the `comp_hi` value (1 means the input is at or above the trial), and bit k-1 is set as the next trial. After the frame `sar_code` holds the unsigned sample code.
- R6: With `start_uni`=0 the bit sent at the MSB position is the inverse of the decision (two's complement). With `start_uni`=1 it is sent unchanged. `sar_code` is never inverted.
- R7: `dout` and `sar_code` change only on a counted falling SCLK edge, never while SCLK is high.
- R8: `dout_oe` and `sstrb_oe` are low whenever `cs_n` is high, and high while it is low.
- R9: SCLK edges seen while `cs_n` is high are ignored, so a frame paused that way resumes where it stopped and yields the same result.
- R10: `conv_done` pulses for one clock at count 24 (short) or 32 (long). The block then idles, and further edges change neither `dout`, `sstrb` nor `sar_code`.
- R11: A start that arrives while a frame is running aborts that frame without a done pulse and begins a new one at that edge.
- R12: A `start_req` pulse takes effect only at the next counted falling edge. Until that edge, outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples SCLK and CS |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select |
| start_req | input | 1 | One-cycle start request from the command decoder |
| start_long | input | 1 | 1 selects long acquisition for the requested frame |
| start_uni | input | 1 | 1 selects unipolar (straight binary), 0 bipolar |
| comp_hi | input | 1 | Comparator: input at or above the current trial code |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout` |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Drive enable for `sstrb` |
| sar_code | output | 14 | Current trial / final code |
| conv_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The properties assume that every SCLK level lasts at least three system clocks, so each falling edge is seen once. They also assume that `cs_n` moves only while SCLK is low and that `comp_hi` settles before the next falling edge. The stimulus holds each SCLK level for five clocks and flips `cs_n` only in the low phase. It issues `start_req` in the middle of a high phase, or at rest for the deferred case. `comp_hi` is derived from a held sample value, so it follows `sar_code` well within a half period.

// File: rtl/xclk_sar_pkg.sv
package xclk_sar_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic long_acq;
    logic unipolar;
  } conv_cmd_t;

endpackage

// File: rtl/xclk_edge_sync.sv
// Brings SCLK and CS into the system clock domain and reports counted falling edges.
module xclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic fall_evt,
  output logic cs_on
);

  logic [SYNC_STAGES:0]   sclk_q;
  logic [SYNC_STAGES-1:0] cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
    end
  end

  assign cs_on    = ~cs_q[SYNC_STAGES-1];
  assign fall_evt = sclk_q[SYNC_STAGES] & ~sclk_q[SYNC_STAGES-1] & cs_on;

endmodule

// File: rtl/xclk_seq_ctrl.sv
// Frame counter, strobe and step decode for one conversion frame.
module xclk_seq_ctrl
  import xclk_sar_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int CMD_FALLS   = 7,
  parameter int SHORT_FRAME = 24,
  parameter int LONG_EXTRA  = 8,
  localparam int CW = $clog2(SHORT_FRAME + LONG_EXTRA + 1),
  localparam int IW = $clog2(RES_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_evt,
  input  logic          start_req,
  input  logic          start_long,
  input  logic          start_uni,
  output logic          start_now,
  output logic          decide,
  output logic          fill,
  output logic [IW-1:0] bit_idx,
  output logic          unipolar,
  output logic          sstrb,
  output logic          conv_done
);

  localparam logic [CW-1:0] CMD_C   = CW'(CMD_FALLS);
  localparam logic [CW-1:0] EXTRA_C = CW'(LONG_EXTRA);
  localparam logic [CW-1:0] FRAME_C = CW'(SHORT_FRAME);
  localparam logic [CW-1:0] RES_C   = CW'(RES_BITS);

  seq_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  conv_cmd_t     cmd_q, cmd_n, pend_cmd_q, pend_cmd_n;
  logic          pend_q, pend_n;
  logic          sstrb_q, sstrb_n;
  logic          done_q, done_n;
  logic [CW-1:0] strobe_at, frame_at, bit_diff;
  logic          run_step;
  logic          ctl_en;

  assign cnt_inc   = cnt_q + 1'b1;
  assign strobe_at = CMD_C + (cmd_q.long_acq ? EXTRA_C : '0);
  assign frame_at  = FRAME_C + (cmd_q.long_acq ? EXTRA_C : '0);
  assign bit_diff  = strobe_at + RES_C - cnt_inc;

  assign start_now = fall_evt & pend_q;
  assign run_step  = fall_evt & (st_q == SEQ_RUN) & ~pend_q;
  assign decide    = run_step & (cnt_inc > strobe_at) & (cnt_inc <= strobe_at + RES_C);
  assign fill      = run_step & ~decide;
  assign bit_idx   = bit_diff[IW-1:0];
  assign unipolar  = cmd_q.unipolar;
  assign ctl_en    = fall_evt | start_req | done_q;

  // Next-state logic
  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    cmd_n      = cmd_q;
    pend_n     = pend_q;
    pend_cmd_n = pend_cmd_q;
    sstrb_n    = sstrb_q;
    done_n     = 1'b0;

    if (start_now) begin
      st_n    = SEQ_RUN;
      cnt_n   = CMD_C;
      cmd_n   = pend_cmd_q;
      sstrb_n = pend_cmd_q.long_acq ? (EXTRA_C == '0) : 1'b1;
      pend_n  = 1'b0;
    end else if (run_step) begin
      cnt_n   = cnt_inc;
      sstrb_n = (cnt_inc == strobe_at);
      if (cnt_inc == frame_at) begin
        st_n    = SEQ_IDLE;
        done_n  = 1'b1;
        sstrb_n = 1'b0;
      end
    end else if (fall_evt) begin
      sstrb_n = 1'b0;
    end

    if (start_req) begin
      pend_n              = 1'b1;
      pend_cmd_n.long_acq = start_long;
      pend_cmd_n.unipolar = start_uni;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      cnt_q      <= '0;
      cmd_q      <= '0;
      pend_q     <= 1'b0;
      pend_cmd_q <= '0;
      sstrb_q    <= 1'b0;
      done_q     <= 1'b0;
    end else if (ctl_en) begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      cmd_q      <= cmd_n;
      pend_q     <= pend_n;
      pend_cmd_q <= pend_cmd_n;
      sstrb_q    <= sstrb_n;
      done_q     <= done_n;
    end
  end

  assign sstrb     = sstrb_q;
  assign conv_done = done_q;

endmodule

// File: rtl/xclk_sar_reg.sv
// Trial-code register and serial output bit.
module xclk_sar_reg #(
  parameter int RES_BITS = 14,
  localparam int IW = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_now,
  input  logic                decide,
  input  logic                fill,
  input  logic [IW-1:0]       bit_idx,
  input  logic                unipolar,
  input  logic                comp_hi,
  output logic [RES_BITS-1:0] code,
  output logic                dout
);

  localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);

  logic [RES_BITS-1:0] code_q, code_n;
  logic                dout_q, dout_n;
  logic                msb_flip;
  logic                reg_en;

  assign msb_flip = ~unipolar & (bit_idx == TOP_IDX);
  assign reg_en   = start_now | decide | fill;

  always_comb begin
    code_n = code_q;
    dout_n = dout_q;
    if (start_now) begin
      code_n               = '0;
      code_n[RES_BITS-1]   = 1'b1;
      dout_n               = 1'b0;
    end else if (decide) begin
      for (int i = 0; i < RES_BITS; i++) begin
        if (i == int'(bit_idx)) begin
          code_n[i] = comp_hi;
        end else if (i + 1 == int'(bit_idx)) begin
          code_n[i] = 1'b1;
        end
      end
      dout_n = comp_hi ^ msb_flip;
    end else if (fill) begin
      dout_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      dout_q <= 1'b0;
    end else if (reg_en) begin
      code_q <= code_n;
      dout_q <= dout_n;
    end
  end

  assign code = code_q;
  assign dout = dout_q;

endmodule

// File: rtl/xclk_sar_seq.sv
// Top: external-clock paced SAR conversion sequencer.
module xclk_sar_seq #(
  parameter int RES_BITS    = 14,
  parameter int CMD_FALLS   = 7,
  parameter int SHORT_FRAME = 24,
  parameter int LONG_EXTRA  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                start_req,
  input  logic                start_long,
  input  logic                start_uni,
  input  logic                comp_hi,
  output logic                dout,
  output logic                dout_oe,
  output logic                sstrb,
  output logic                sstrb_oe,
  output logic [RES_BITS-1:0] sar_code,
  output logic                conv_done
);

  localparam int IW = $clog2(RES_BITS);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          fall_evt;
  logic          cs_on;
  logic          start_now;
  logic          decide;
  logic          fill;
  logic [IW-1:0] bit_idx;
  logic          unipolar;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  xclk_edge_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) edge_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .fall_evt (fall_evt),
    .cs_on    (cs_on)
  );

  xclk_seq_ctrl #(
    .RES_BITS    (RES_BITS),
    .CMD_FALLS   (CMD_FALLS),
    .SHORT_FRAME (SHORT_FRAME),
    .LONG_EXTRA  (LONG_EXTRA)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fall_evt   (fall_evt),
    .start_req  (start_req),
    .start_long (start_long),
    .start_uni  (start_uni),
    .start_now  (start_now),
    .decide     (decide),
    .fill       (fill),
    .bit_idx    (bit_idx),
    .unipolar   (unipolar),
    .sstrb      (sstrb),
    .conv_done  (conv_done)
  );

  xclk_sar_reg #(
    .RES_BITS (RES_BITS)
  ) sar_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_now (start_now),
    .decide    (decide),
    .fill      (fill),
    .bit_idx   (bit_idx),
    .unipolar  (unipolar),
    .comp_hi   (comp_hi),
    .code      (sar_code),
    .dout      (dout)
  );

  assign dout_oe  = cs_on;
  assign sstrb_oe = cs_on;

endmodule

// File: rtl/xclk_sar_chk.sv
// Temporal checks, bound to the sequencer top.
module xclk_sar_chk #(
  parameter int RES_BITS = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fall_evt,
  input logic                start_now,
  input logic                sstrb,
  input logic                dout,
  input logic [RES_BITS-1:0] sar_code,
  input logic                conv_done
);

  // R2 / R3: strobe lasts one counted period
  assert_strobe_one_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrb && fall_evt && !start_now) |=> !sstrb);

  // R4: frame ends on a zero-filled position
  assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !dout);

  // R5: trial code moves only on a counted falling edge
  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sar_code));

  // R7: serial bit moves only on a counted falling edge
  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(dout));

  // R10: done is a single-cycle pulse with the strobe low
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  assert_done_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !sstrb);

endmodule

bind xclk_sar_seq xclk_sar_chk #(
  .RES_BITS (RES_BITS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fall_evt  (fall_evt),
  .start_now (start_now),
  .sstrb     (sstrb),
  .dout      (dout),
  .sar_code  (sar_code),
  .conv_done (conv_done)
);

// File: tb/xclk_sar_seq_tb_top.sv
module xclk_sar_seq_tb_top;

  localparam int RB = 14;

  logic          clk = 1'b0;
  logic          rst_n, sclk, cs_n, start_req, start_long, start_uni;
  logic [RB-1:0] sample_v, sar_code;
  logic          comp_hi, dout, dout_oe, sstrb, sstrb_oe, conv_done;
  int            checks = 0;
  int            bad = 0;
  int            done_cnt = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  assign comp_hi = (sample_v >= sar_code);

  xclk_sar_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .start_req  (start_req),
    .start_long (start_long),
    .start_uni  (start_uni),
    .comp_hi    (comp_hi),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .sstrb      (sstrb),
    .sstrb_oe   (sstrb_oe),
    .sar_code   (sar_code),
    .conv_done  (conv_done)
  );

  always @(posedge clk) if (rst_n && conv_done) done_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; wait_clk(5);
    sclk = 1'b0; wait_clk(5);
  endtask

  task automatic start_pulse(input bit lng, input bit uni);
    sclk = 1'b1; wait_clk(2);
    start_req = 1'b1; start_long = lng; start_uni = uni;
    wait_clk(1);
    start_req = 1'b0; wait_clk(2);
    sclk = 1'b0; wait_clk(5);
  endtask

  task automatic check_start_edge(input bit lng);
    chk(sstrb == !lng, lng ? "R3" : "R2", "strobe at start edge", sstrb, !lng);
    chk(sar_code == 14'h2000, "R5", "first trial code", sar_code, 14'h2000);
  endtask

  task automatic frame_body(input logic [RB-1:0] s, input bit lng, input bit uni,
                            input int pause_at);
    int strobe_exp, frame_end, first, hits, tail_bad, mid_bad, done_at, done_hits;
    int d0, idle_bad;
    logic [RB-1:0] cap, exp_word;
    logic pre;
    string wreq;
    strobe_exp = lng ? 15 : 7;
    frame_end  = lng ? 32 : 24;
    first      = sstrb ? 7 : 0;
    hits       = sstrb ? 1 : 0;
    tail_bad = 0; mid_bad = 0; done_at = 0; done_hits = 0; idle_bad = 0;
    cap = '0;
    exp_word = uni ? s : (s ^ 14'h2000);
    for (int n = 8; n <= frame_end; n++) begin
      if (n == pause_at) begin
        cs_n = 1'b1; wait_clk(4);
        chk(!dout_oe && !sstrb_oe, "R8", "drivers off with CS high",
            {dout_oe, sstrb_oe}, 0);
        for (int k = 0; k < 3; k++) sclk_pulse();
        cs_n = 1'b0; wait_clk(4);
        chk(dout_oe && sstrb_oe, "R8", "drivers on with CS low",
            {dout_oe, sstrb_oe}, 3);
      end
      d0 = done_cnt;
      pre = dout;
      sclk = 1'b1; wait_clk(5);
      if (dout != pre) mid_bad++;
      sclk = 1'b0; wait_clk(5);
      if (done_cnt != d0) begin done_at = n; done_hits += done_cnt - d0; end
      if (sstrb) begin hits++; if (first == 0) first = n; end
      if (n > strobe_exp && n <= strobe_exp + RB) cap = {cap[RB-2:0], dout};
      else if (dout) tail_bad++;
    end
    chk(first == strobe_exp && hits == 1, lng ? "R3" : "R2", "strobe position",
        first, strobe_exp);
    wreq = (pause_at != 0) ? "R9" : (uni ? "R4" : "R6");
    chk(cap == exp_word, wreq, "serial word", cap, exp_word);
    chk(tail_bad == 0, "R4", "zero positions", tail_bad, 0);
    chk(mid_bad == 0, "R7", "dout moved in high phase", mid_bad, 0);
    chk(done_at == frame_end && done_hits == 1, "R10", "done edge", done_at, frame_end);
    chk(sar_code == s, "R5", "final code", sar_code, s);
    d0 = done_cnt;
    for (int k = 0; k < 3; k++) begin
      sclk_pulse();
      if (sstrb || dout) idle_bad++;
    end
    chk(idle_bad == 0 && done_cnt == d0 && sar_code == s, "R10", "idle after frame",
        idle_bad, 0);
  endtask

  task automatic run_frame(input logic [RB-1:0] s, input bit lng, input bit uni,
                           input int pause_at);
    sample_v = s;
    for (int k = 0; k < 6; k++) sclk_pulse();
    start_pulse(lng, uni);
    check_start_edge(lng);
    frame_body(s, lng, uni, pause_at);
  endtask

  task automatic test_reset();
    chk(dout == 0 && sstrb == 0 && conv_done == 0, "R1", "reset outputs",
        {dout, sstrb, conv_done}, 0);
    chk(sar_code == 0, "R1", "reset code", sar_code, 0);
    chk(!dout_oe && !sstrb_oe, "R8", "drivers off at reset", {dout_oe, sstrb_oe}, 0);
  endtask

  task automatic test_abort();
    int d0;
    d0 = done_cnt;
    sample_v = 14'h0F0F;
    for (int k = 0; k < 6; k++) sclk_pulse();
    start_pulse(1'b0, 1'b1);
    for (int k = 0; k < 5; k++) sclk_pulse();
    sample_v = 14'h3A11;
    start_pulse(1'b1, 1'b1);
    check_start_edge(1'b1);
    frame_body(14'h3A11, 1'b1, 1'b1, 0);
    chk(done_cnt - d0 == 1, "R11", "aborted frame gave no done", done_cnt - d0, 1);
  endtask

  task automatic test_deferred();
    sample_v = 14'h0456;
    start_req = 1'b1; start_long = 1'b0; start_uni = 1'b1;
    wait_clk(1);
    start_req = 1'b0;
    wait_clk(20);
    chk(sstrb == 0 && sar_code == 14'h3A11, "R12", "no action before edge",
        sar_code, 14'h3A11);
    sclk_pulse();
    check_start_edge(1'b0);
    frame_body(14'h0456, 1'b0, 1'b1, 0);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1;
    start_req = 1'b0; start_long = 1'b0; start_uni = 1'b0;
    sample_v = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    test_reset();
    cs_n = 1'b0; wait_clk(4);
    run_frame(14'h2A5C, 1'b0, 1'b1, 0);
    run_frame(14'h0001, 1'b0, 1'b0, 0);
    run_frame(14'h3FFF, 1'b1, 1'b1, 0);
    run_frame(14'h2000, 1'b1, 1'b0, 0);
    run_frame(14'h0000, 1'b0, 1'b1, 0);
    run_frame(14'h1357, 1'b0, 1'b1, 10);
    run_frame(14'h2C0F, 1'b1, 1'b0, 20);
    test_abort();
    test_deferred();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule